// File: doc/BRIEF.md
# Multiplexed LCD Segment Driver

This block drives a passive LCD panel built from 25 segment lines and 3 common lines, run at one-third duty so that up to 75 points can be shown. Display content is kept in two 40-bit image halves, called A and B. A serial front end loads each half on its own with a single-cycle write strobe. A constant map inside the block ties every (segment, common) point to one stored bit. In the second half, five bit positions have no point.

A divider on the system clock cuts time into common slots. In each slot one common is selected. After every third slot the drive polarity flips, which keeps the average voltage across each point at zero. Every output pin carries a 2-bit level code, and an external analog stage turns that code into one of the four one-third-bias voltages. An external blank input forces every point dark without changing the stored image. After reset the panel stays dark until image data has been written.

Top module: `lcd_mux_driver`

## Requirements
- R1: While reset is held, and on the first cycle after it, common 0 carries code 3 and commons 1 and 2 carry code 1. Every segment carries code 2, `img_valid` is 0, and both image halves are cleared to zero.
- R2: The commons are selected one at a time in the order 0, 1, 2, 0 and so on. In each slot exactly one common carries the select code and the other two carry the non-select code.
- R3: Each common slot lasts exactly `SLOT_DIV` clock cycles. The default of 8192 at an 8 MHz clock gives a frame rate near 325.5 Hz.
- R4: Level codes run 0 to 3, with code k standing for k/3 of the bias voltage. In positive polarity a selected common is 3, a non-selected common is 1, a lit segment is 0 and a dark segment is 2. In negative polarity these are 0, 2, 3 and 1. Polarity starts positive and flips only when the selection wraps from common 2 back to common 0.
- R5: Point p = 3·s + c (segment s, common c) is lit when its bit is 1 and dark when its bit is 0. For p < 40 the bit is bit p of half A. For p ≥ 40, let q = p − 40. The bit is then bit q of half B when q < 3, bit q + 1 + (q − 3)/4 (integer division) when q < 19, and bit q + 5 otherwise.
- R6: A write with `wr_sel_b` = 0 replaces half A only, and a write with `wr_sel_b` = 1 replaces half B only. The new image appears on the segment outputs on the second clock edge after the strobe is sampled.
- R7: Bits 3, 8, 13, 18 and 23 of half B drive no point. Setting them lights nothing.
- R8: While `blank` is 1, every segment carries its dark code and the commons keep scanning. When `blank` returns to 0, the stored image reappears unchanged. `blank` acts on the next clock edge.
- R9: From reset until the first write to either half, `img_valid` stays 0 and all segments stay dark even with `blank` low. The first write sets `img_valid` to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Image write strobe, one cycle per write |
| wr_sel_b | input | 1 | Selects the half to write: 0 for A, 1 for B |
| wr_data | input | 40 | Image bits for the selected half |
| blank | input | 1 | 1 forces every point dark |
| com_lvl | output | 6 | Level code per common; bits [2c+1:2c] belong to common c |
| seg_lvl | output | 50 | Level code per segment; bits [2s+1:2s] belong to segment s |
| img_valid | output | 1 | Set once any image data has been written since reset |

## Verification
The bench infers the active common and the polarity from the common codes alone. It then checks every segment code against a model that walks half B and skips the reserved positions. A design with an off-by-one in the skip arithmetic would light the wrong segment near one of the reserved bits. The bench writes a half consisting only of reserved bits to catch a map that treats those bits as real points. It writes A and B in turn to show that one half survives a write to the other, which a shared write enable would break. It times successive slot edges and the polarity flip, so a divider that is one cycle off or a polarity that toggles every slot shows up. It also checks that the panel is dark after reset with blank low, so a design that shows its cleared buffers as "valid" or ignores the written flag is reported.

// File: rtl/lcdm_pkg.sv
package lcdm_pkg;

    localparam int NUM_SEG = 25;
    localparam int NUM_COM = 3;
    localparam int HALF_W  = 40;
    localparam int COM_W   = $clog2(NUM_COM);
    localparam int LVL_W   = 2;

    // Drive level code: value k stands for k/3 of the bias voltage.
    typedef enum logic [LVL_W-1:0] {
        LVL_GND      = 2'd0,
        LVL_THIRD    = 2'd1,
        LVL_TWOTHIRD = 2'd2,
        LVL_FULL     = 2'd3
    } lvl_e;

    // Scan position: active common and polarity of the current frame.
    typedef struct packed {
        logic             neg;
        logic [COM_W-1:0] com;
    } scan_t;

    // Both image halves; half A occupies the low bits.
    typedef struct packed {
        logic [HALF_W-1:0] b;
        logic [HALF_W-1:0] a;
    } image_t;

    // Index into the flattened image for point p = seg*NUM_COM + com.
    // Half B skips its reserved positions 3, 8, 13, 18 and 23.
    function automatic int point_src(input int p);
        int q;
        if (p < HALF_W) return p;
        q = p - HALF_W;
        if (q < 3)  return HALF_W + q;
        if (q < 19) return HALF_W + q + 1 + (q - 3) / 4;
        return HALF_W + q + 5;
    endfunction

    function automatic lvl_e com_code(input logic sel, input logic neg);
        if (neg) return sel ? LVL_GND  : LVL_TWOTHIRD;
        else     return sel ? LVL_FULL : LVL_THIRD;
    endfunction

    function automatic lvl_e seg_code(input logic on, input logic neg);
        if (neg) return on ? LVL_FULL : LVL_THIRD;
        else     return on ? LVL_GND  : LVL_TWOTHIRD;
    endfunction

endpackage

// File: rtl/lcd_timebase.sv
module lcd_timebase
    import lcdm_pkg::*;
#(
    parameter int SLOT_DIV = 8192
) (
    input  logic  clk,
    input  logic  rst,
    output scan_t scan_o
);
    localparam int CNT_W = $clog2(SLOT_DIV + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOT_DIV - 1);
    localparam logic [COM_W-1:0] COM_LAST = COM_W'(NUM_COM - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [COM_W-1:0] com_q;
    logic             neg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            com_q <= '0;
            neg_q <= 1'b0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
            if (com_q == COM_LAST) begin
                com_q <= '0;
                neg_q <= ~neg_q;
            end else begin
                com_q <= com_q + 1'b1;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign scan_o.com = com_q;
    assign scan_o.neg = neg_q;

    // R2: selection only ever steps to the next common, wrapping after the last
    a_r2_com_step: assert property (@(posedge clk) disable iff (rst)
        (com_q != $past(com_q)) |->
            (com_q == (($past(com_q) == COM_LAST) ? '0 : $past(com_q) + 1'b1)));

    // R2: selected common index stays in range
    a_r2_com_range: assert property (@(posedge clk) disable iff (rst)
        com_q <= COM_LAST);

    // R3: mid-slot the common does not move
    a_r3_slot_hold: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |-> $stable(com_q));

    // R4: polarity changes only at the wrap from the last common to common 0
    a_r4_pol_wrap: assert property (@(posedge clk) disable iff (rst)
        !$stable(neg_q) |-> ($past(com_q) == COM_LAST && com_q == '0));

endmodule

// File: rtl/lcd_frame_store.sv
module lcd_frame_store
    import lcdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel_b,
    input  logic [HALF_W-1:0] wr_data,
    output image_t            img_o,
    output logic              written_o
);
    localparam int NUM_HALF = 2;

    logic [HALF_W-1:0] half_w [NUM_HALF];

    for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
        logic [HALF_W-1:0] q;
        logic              hit;

        assign hit = wr_en && (wr_sel_b == (h == 1));

        always_ff @(posedge clk) begin
            if (rst)      q <= '0;
            else if (hit) q <= wr_data;
        end

        assign half_w[h] = q;
    end

    always_ff @(posedge clk) begin
        if (rst)        written_o <= 1'b0;
        else if (wr_en) written_o <= 1'b1;
    end

    assign img_o.a = half_w[0];
    assign img_o.b = half_w[1];

    // R6: writing A leaves B untouched
    a_r6_keep_b: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel_b) |=> $stable(img_o.b));

    // R6: writing B leaves A untouched
    a_r6_keep_a: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel_b) |=> $stable(img_o.a));

    // R9: once set, the written flag stays set until reset
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        written_o |=> written_o);

endmodule

// File: rtl/lcd_level_encoder.sv
module lcd_level_encoder
    import lcdm_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  scan_t                    scan,
    input  image_t                   img,
    input  logic                     disp_on,
    output logic [NUM_COM*LVL_W-1:0] com_lvl_o,
    output logic [NUM_SEG*LVL_W-1:0] seg_lvl_o
);
    localparam int ROW_W = 1 << COM_W;

    logic [2*HALF_W-1:0] img_flat;
    logic                unused_resv;

    assign img_flat    = img;
    assign unused_resv = ^{img.b[3], img.b[8], img.b[13], img.b[18], img.b[23]};

    // Common lanes
    for (genvar c = 0; c < NUM_COM; c++) begin : g_com
        lvl_e cq;

        always_ff @(posedge clk) begin
            if (rst) begin
                if (c == 0) cq <= LVL_FULL;
                else        cq <= LVL_THIRD;
            end else begin
                cq <= com_code(scan.com == COM_W'(c), scan.neg);
            end
        end

        assign com_lvl_o[c*LVL_W +: LVL_W] = cq;
    end

    // Segment lanes: each picks its bit for the active common from a fixed map
    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        logic [ROW_W-1:0] row;
        logic             lit;
        lvl_e             sq;

        for (genvar c = 0; c < ROW_W; c++) begin : g_pt
            if (c < NUM_COM) begin : g_real
                assign row[c] = img_flat[point_src(s * NUM_COM + c)];
            end else begin : g_pad
                assign row[c] = 1'b0;
            end
        end

        assign lit = disp_on & row[scan.com];

        always_ff @(posedge clk) begin
            if (rst) sq <= LVL_TWOTHIRD;
            else     sq <= seg_code(lit, scan.neg);
        end

        assign seg_lvl_o[s*LVL_W +: LVL_W] = sq;

        // R8 / R9: with the display gated off, every segment shows its dark code
        a_r8_dark_seg: assert property (@(posedge clk) disable iff (rst)
            !disp_on |=> (sq == ($past(scan.neg) ? LVL_THIRD : LVL_TWOTHIRD)));
    end

endmodule

// File: rtl/lcd_mux_driver.sv
module lcd_mux_driver
    import lcdm_pkg::*;
#(
    parameter int SLOT_DIV = 8192
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic                     wr_sel_b,
    input  logic [HALF_W-1:0]        wr_data,
    input  logic                     blank,
    output logic [NUM_COM*LVL_W-1:0] com_lvl,
    output logic [NUM_SEG*LVL_W-1:0] seg_lvl,
    output logic                     img_valid
);
    scan_t  scan;
    image_t img;
    logic   written;
    logic   disp_on;

    lcd_timebase #(.SLOT_DIV(SLOT_DIV)) u_timebase (
        .clk    (clk),
        .rst    (rst),
        .scan_o (scan)
    );

    lcd_frame_store u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel_b  (wr_sel_b),
        .wr_data   (wr_data),
        .img_o     (img),
        .written_o (written)
    );

    assign disp_on = written & ~blank;

    lcd_level_encoder u_enc (
        .clk       (clk),
        .rst       (rst),
        .scan      (scan),
        .img       (img),
        .disp_on   (disp_on),
        .com_lvl_o (com_lvl),
        .seg_lvl_o (seg_lvl)
    );

    assign img_valid = written;

    // R9: nothing is written while the flag is low, so the panel stays dark
    a_r9_dark_until_write: assert property (@(posedge clk) disable iff (rst)
        (!written && !wr_en) |=> !img_valid);

endmodule

// File: tb/lcd_mux_driver_tb.sv
module lcd_mux_driver_tb;
    import lcdm_pkg::*;

    localparam int SLOT = 16;
    localparam int WD   = 150000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic              wr_sel_b = 1'b0;
    logic [HALF_W-1:0] wr_data = '0;
    logic              blank = 1'b0;
    logic [5:0]        com_lvl;
    logic [49:0]       seg_lvl;
    logic              img_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [39:0] m_a = '0;
    logic [39:0] m_b = '0;
    bit          m_written = 1'b0;

    always #2 clk = ~clk;

    lcd_mux_driver #(.SLOT_DIV(SLOT)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel_b  (wr_sel_b),
        .wr_data   (wr_data),
        .blank     (blank),
        .com_lvl   (com_lvl),
        .seg_lvl   (seg_lvl),
        .img_valid (img_valid)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model of the point map: walk half B, skipping the reserved positions.
    function automatic bit point_val(input int p);
        int cnt;
        if (p < 40) return m_a[p];
        cnt = 0;
        for (int k = 0; k < 40; k++) begin
            if (k == 3 || k == 8 || k == 13 || k == 18 || k == 23) continue;
            if (cnt == p - 40) return m_b[k];
            cnt++;
        end
        return 1'b0;
    endfunction

    function automatic logic [49:0] exp_seg(input int c, input bit pol);
        logic [49:0] v;
        bit          on;
        bit          lit;
        on = m_written && !blank;
        for (int s = 0; s < 25; s++) begin
            lit = on && point_val(s * 3 + c);
            if (pol) v[2*s +: 2] = lit ? 2'd3 : 2'd1;
            else     v[2*s +: 2] = lit ? 2'd0 : 2'd2;
        end
        return v;
    endfunction

    task automatic decode(output int c, output bit pol, output bit ok);
        int n0, n1, n2, n3, c0, c3;
        n0 = 0; n1 = 0; n2 = 0; n3 = 0; c0 = -1; c3 = -1;
        for (int k = 0; k < 3; k++) begin
            case (com_lvl[2*k +: 2])
                2'd0: begin n0++; c0 = k; end
                2'd1: n1++;
                2'd2: n2++;
                default: begin n3++; c3 = k; end
            endcase
        end
        ok = 1'b1; c = 0; pol = 1'b0;
        if (n3 == 1 && n1 == 2)      begin c = c3; pol = 1'b0; end
        else if (n0 == 1 && n2 == 2) begin c = c0; pol = 1'b1; end
        else ok = 1'b0;
    endtask

    task automatic check_now(input string req);
        int c; bit pol; bit ok;
        logic [49:0] e;
        decode(c, pol, ok);
        if (!ok) begin
            chk(1'b0, "R2 common codes", {58'd0, com_lvl}, 64'd0);
            return;
        end
        e = exp_seg(c, pol);
        chk(seg_lvl == e, req, {14'd0, seg_lvl}, {14'd0, e});
    endtask

    task automatic check_slots(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            check_now(req);
            repeat (SLOT) @(negedge clk);
        end
    endtask

    task automatic do_write(input bit selb, input logic [39:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel_b = selb; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (selb) m_b = d; else m_a = d;
        m_written = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        m_a = '0; m_b = '0; m_written = 1'b0;
        repeat (3) @(negedge clk);
        chk(com_lvl == 6'b01_01_11, "R1 common reset", {58'd0, com_lvl}, 64'b01_01_11);
        chk(seg_lvl == {25{2'd2}}, "R1 segment reset", {14'd0, seg_lvl}, {14'd0, {25{2'd2}}});
        chk(img_valid == 1'b0, "R1 R9 flag reset", {63'd0, img_valid}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(com_lvl == 6'b01_01_11, "R1 first cycle", {58'd0, com_lvl}, 64'b01_01_11);
    endtask

    task automatic t_scan;
        int pc, c, cyc; bit pp, p, ok;
        decode(pc, pp, ok);
        for (int i = 0; i < 7; i++) begin
            cyc = 0;
            do begin
                @(negedge clk);
                cyc++;
                decode(c, p, ok);
            end while (ok && c == pc && cyc < 4 * SLOT);
            if (i > 0) chk(cyc == SLOT, "R3 slot length", cyc, SLOT);
            chk(ok && c == (pc + 1) % 3, "R2 common order", c, (pc + 1) % 3);
            chk(p == ((c == 0) ? !pp : pp), "R4 polarity flip", p, (c == 0) ? !pp : pp);
            pc = c; pp = p;
        end
    endtask

    task automatic t_dark_start;
        blank = 1'b0;
        check_slots("R9 dark before write", 3);
        chk(img_valid == 1'b0, "R9 flag low", {63'd0, img_valid}, 64'd0);
    endtask

    task automatic t_write_a;
        do_write(1'b0, 40'hA5_3C_96_0F_E1);
        chk(img_valid == 1'b1, "R9 flag set", {63'd0, img_valid}, 64'd1);
        check_slots("R5 half A image", 6);
    endtask

    task automatic t_write_b;
        do_write(1'b1, 40'h5A_C3_69_F0_1E);
        check_slots("R6 B written A kept", 3);
        do_write(1'b0, 40'h0F_F0_33_CC_55);
        check_slots("R6 A rewritten B kept", 3);
    endtask

    task automatic t_reserved;
        do_write(1'b0, 40'd0);
        do_write(1'b1, 40'h00_0084_2108);
        check_slots("R7 reserved only", 3);
        do_write(1'b1, 40'hFF_FF7B_DEF7);
        check_slots("R7 all but reserved", 3);
        do_write(1'b1, 40'hFF_FFFF_FFFF);
        check_slots("R7 all ones", 3);
    endtask

    task automatic t_blank;
        do_write(1'b0, 40'h12_3456_789A);
        @(negedge clk); blank = 1'b1;
        @(negedge clk);
        check_slots("R8 blank dark", 3);
        @(negedge clk); blank = 1'b0;
        @(negedge clk);
        check_slots("R8 image returns", 3);
    endtask

    task automatic t_rereset;
        t_reset;
        check_slots("R9 dark after reset", 3);
        do_write(1'b0, 40'hFF_FFFF_FFFF);
        check_slots("R1 R5 B cleared by reset", 3);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset;
        t_dark_start;
        t_scan;
        t_write_a;
        t_write_b;
        t_reserved;
        t_blank;
        t_rereset;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule